// File: doc/BRIEF.md
# Drop-Oldest Command Queue with Batched Overflow Reporting

This block holds up to 32 commands for one subsystem (a sound-register stream or a display stream) in first-in, first-out order. Producers never stall. When the queue is full and another command arrives without a read in the same cycle, the oldest queued command is discarded and the new one is stored. In that case the freshest command wins over the stalest.

Every eviction adds one to a drop counter. A quiet-window timer restarts on each eviction. Once a full window passes with no eviction, the block sends out a five-byte overflow record on a byte-serial output and clears the counter. The record names the subsystem and carries the number of drops accumulated since the previous record. Overflow is therefore reported in batches, and a burst of evictions produces one record.

Top module: `cmdq_overflow_reporter`

## Requirements
- R1: Commands leave the queue in the order they were written. The queue holds at most DEPTH (32) entries. `q_full` is high at 32 entries and `q_empty` is high at zero entries.
- R2: A write into a full queue with no read in the same cycle evicts the oldest entry and stores the new one. The queue stays full.
- R3: Each eviction adds one to the drop counter. A record carries the total number of evictions since the previous record, and the counter is zero right after a record starts.
- R4: A record occupies five consecutive cycles with `evt_valid` high. The bytes are, in order: 0x03 (overflow code), 0x03 (bytes that follow), subsystem identifier, drop count low byte, drop count high byte. `evt_last` is high only on the fifth byte.
- R5: The subsystem byte equals the SUBSYS_ID parameter: 0x01 for the sound-register queue, 0x02 for the display queue.
- R6: No record is produced while the drop counter is zero.
- R7: The drop counter saturates at 0xFFFF instead of wrapping.
- R8: The first record byte appears QUIET_CYCLES+1 clock edges after the edge that registered the last eviction. Every new eviction restarts the window.
- R9: A simultaneous read and write on a full queue performs an ordinary pop and push. It is not counted as a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push a command this cycle |
| wr_data | input | DATA_W | Command to push |
| rd_en | input | 1 | Pop the head command (ignored when empty) |
| rd_data | output | DATA_W | Head command (show-ahead) |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds DEPTH entries |
| evt_valid | output | 1 | Record byte present this cycle |
| evt_byte | output | 8 | Record byte |
| evt_last | output | 1 | Final byte of a record |

## Verification
The hardest states to reach from the ports are saturation of the drop counter and a drop counter that must survive several restarted windows. The bench fills the queue and then performs 65,540 back-to-back writes, which pushes the counter past 0xFFFF. It then checks that the record reports 0xFFFF and that the queue holds exactly the last 32 values written. To cover restarted windows, the bench spaces single evictions just inside the quiet window, checks that no record appears between them, and then times the single record from the last eviction.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [7:0] OVF_CODE  = 8'h03;
  localparam logic [7:0] OVF_LEN   = 8'h03;
  localparam int         REC_BYTES = 5;

  // saturating 16-bit increment
  function automatic logic [15:0] sat_inc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  // byte of the overflow record at position idx
  function automatic logic [7:0] rec_byte(input logic [2:0] idx,
                                          input logic [7:0] subsys,
                                          input logic [15:0] cnt);
    case (idx)
      3'd0:    return OVF_CODE;
      3'd1:    return OVF_LEN;
      3'd2:    return subsys;
      3'd3:    return cnt[7:0];
      default: return cnt[15:8];
    endcase
  endfunction
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              q_empty,
  output logic              q_full,
  output logic              drop_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic              pop;

  assign q_empty  = (count == '0);
  assign q_full   = (count == CW'(DEPTH));
  assign pop      = rd_en && !q_empty;
  assign drop_evt = wr_en && q_full && !pop;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= adv(wptr);
      if (pop || drop_evt) rptr <= adv(rptr);
      if (wr_en && !pop && !drop_evt) count <= count + 1'b1;
      else if (pop && !wr_en)         count <= count - 1'b1;
    end
  end

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  evict_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> q_full);
  // R9
  pushpop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && wr_en && rd_en) |=> q_full);
endmodule

// File: rtl/cmdq_drop_tracker.sv
module cmdq_drop_tracker
  import cmdq_pkg::*;
#(
  parameter int QUIET_CYCLES = 5_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drop_evt,
  input  logic        ser_busy,
  output logic [15:0] drop_cnt,
  output logic        fire
);
  localparam int TW = $clog2(QUIET_CYCLES + 1);

  logic [TW-1:0] quiet_t;
  logic          window_done;

  assign window_done = (quiet_t == TW'(QUIET_CYCLES));
  assign fire = (drop_cnt != 16'd0) && window_done && !ser_busy && !drop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_cnt <= '0;
      quiet_t  <= '0;
    end else if (drop_evt) begin
      drop_cnt <= sat_inc16(drop_cnt);
      quiet_t  <= '0;
    end else if (fire) begin
      drop_cnt <= '0;
    end else if (drop_cnt != 16'd0 && !window_done) begin
      quiet_t  <= quiet_t + 1'b1;
    end
  end

  // R3
  drop_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && drop_cnt != 16'hFFFF) |=> drop_cnt == $past(drop_cnt) + 16'd1);
  // R3
  fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> drop_cnt == 16'd0);
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && drop_cnt == 16'hFFFF) |=> drop_cnt == 16'hFFFF);
  // R8
  drop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !fire);
endmodule

// File: rtl/cmdq_evt_ser.sv
module cmdq_evt_ser
  import cmdq_pkg::*;
#(
  parameter logic [7:0] SUBSYS_ID = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [15:0] drop_cnt,
  output logic        ser_busy,
  output logic        evt_valid,
  output logic [7:0]  evt_byte,
  output logic        evt_last
);
  logic        active;
  logic [2:0]  idx;
  logic [15:0] snap;

  assign ser_busy  = active;
  assign evt_valid = active;
  assign evt_last  = active && (idx == 3'(REC_BYTES - 1));
  assign evt_byte  = active ? rec_byte(idx, SUBSYS_ID, snap) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      snap   <= '0;
    end else if (fire) begin
      active <= 1'b1;
      idx    <= '0;
      snap   <= drop_cnt;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (evt_last) active <= 1'b0;
    end
  end

  // R4
  rec_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_last) |=> evt_valid);
  // R4
  rec_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> evt_byte == OVF_CODE);
  // R6
  rec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> drop_cnt != 16'd0);
endmodule

// File: rtl/cmdq_overflow_reporter.sv
module cmdq_overflow_reporter #(
  parameter int         DATA_W       = 16,
  parameter int         DEPTH        = 32,
  parameter int         QUIET_CYCLES = 5_000_000,
  parameter logic [7:0] SUBSYS_ID    = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              q_empty,
  output logic              q_full,
  output logic              evt_valid,
  output logic [7:0]        evt_byte,
  output logic              evt_last
);
  logic        drop_evt;
  logic        fire;
  logic        ser_busy;
  logic [15:0] drop_cnt;

  cmdq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .q_empty(q_empty), .q_full(q_full),
    .drop_evt(drop_evt));

  cmdq_drop_tracker #(.QUIET_CYCLES(QUIET_CYCLES)) u_track (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt), .ser_busy(ser_busy),
    .drop_cnt(drop_cnt), .fire(fire));

  cmdq_evt_ser #(.SUBSYS_ID(SUBSYS_ID)) u_ser (
    .clk(clk), .rst_n(rst_n), .fire(fire), .drop_cnt(drop_cnt),
    .ser_busy(ser_busy), .evt_valid(evt_valid), .evt_byte(evt_byte),
    .evt_last(evt_last));

  // R2
  evict_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !q_empty);
endmodule

// File: tb/test_cmdq_overflow_reporter.sv
module test_cmdq_overflow_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEP   = 32;
  localparam int QW    = 20;
  localparam logic [7:0] SID = 8'h02;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          q_empty, q_full, evt_valid, evt_last;
  logic [7:0]    evt_byte;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_drop = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmdq_overflow_reporter #(.DATA_W(DW), .DEPTH(DEP), .QUIET_CYCLES(QW),
                           .SUBSYS_ID(SID)) i_cmdq_overflow_reporter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .q_empty(q_empty), .q_full(q_full),
    .evt_valid(evt_valid), .evt_byte(evt_byte), .evt_last(evt_last));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000 && !done) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog: act %0d cycles exp below 190000", cyc);
    summary();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    if (q_full && !rd_en) last_drop = cyc + 1;
    wr_en = 1'b1; wr_data = DW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input int exp, input string req);
    check(!q_empty, req, int'(q_empty), 0);
    check(rd_data == DW'(exp), req, int'(rd_data), exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic fill(input int base);
    for (int i = 0; i < DEP; i++) push(base + i);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (evt_valid) seen = 1;
      @(negedge clk);
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic get_event(input int exp_cnt, input string req);
    int waited = 0;
    int exp_b[5];
    exp_b[0] = 3; exp_b[1] = 3; exp_b[2] = SID;
    exp_b[3] = exp_cnt & 8'hFF; exp_b[4] = (exp_cnt >> 8) & 8'hFF;
    while (!evt_valid && waited < QW + 40) begin
      @(negedge clk); waited++;
    end
    check(evt_valid, {req, " R6 record present"}, int'(evt_valid), 1);
    // R8 timing from last drop edge
    check(cyc - last_drop == QW + 1, "R8 record latency", cyc - last_drop, QW + 1);
    for (int b = 0; b < 5; b++) begin
      check(evt_valid, "R4 contiguous", int'(evt_valid), 1);
      check(evt_byte == 8'(exp_b[b]), (b == 2) ? "R5 subsystem" : {req, " R4 byte"},
            int'(evt_byte), exp_b[b]);
      check(evt_last == (b == 4), "R4 last flag", int'(evt_last), int'(b == 4));
      @(negedge clk);
    end
    check(!evt_valid, "R4 record ends", int'(evt_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(q_empty, "R1 reset empty", int'(q_empty), 1);
    check(!q_full, "R1 reset not full", int'(q_full), 0);
    check(!evt_valid, "R6 reset no record", int'(evt_valid), 0);

    // R1 / R6: fill exactly, no drops, no record
    fill(0);
    check(q_full, "R1 full at depth", int'(q_full), 1);
    quiet(3 * QW, "R6 no record with zero drops");
    for (int i = 0; i < DEP; i++) pop_chk(i, "R1 order");
    check(q_empty, "R1 empty after drain", int'(q_empty), 1);

    // R2 / R3: five evictions, one record
    fill(0);
    for (int k = 0; k < 5; k++) push(100 + k);
    get_event(5, "R3 batch of five");
    for (int i = 5; i < DEP; i++) pop_chk(i, "R2 survivors");
    for (int k = 0; k < 5; k++) pop_chk(100 + k, "R2 newest kept");
    check(q_empty, "R2 drained", int'(q_empty), 1);

    // R9: read+write on full is not a drop
    fill(0);
    for (int k = 0; k < 4; k++) begin
      check(rd_data == DW'(k), "R9 head", int'(rd_data), k);
      rd_en = 1'b1; wr_en = 1'b1; wr_data = DW'(200 + k);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
    end
    check(q_full, "R9 stays full", int'(q_full), 1);
    quiet(3 * QW, "R9 no record after pushpop");
    for (int i = 4; i < DEP; i++) pop_chk(i, "R9 order");
    for (int k = 0; k < 4; k++) pop_chk(200 + k, "R9 pushed kept");

    // R8: each drop restarts the window
    fill(0);
    push(300);
    quiet(QW - 2, "R8 window restart 1");
    push(301);
    quiet(QW - 2, "R8 window restart 2");
    push(302);
    get_event(3, "R3 restarted window total");
    for (int i = 3; i < DEP; i++) pop_chk(i, "R8 survivors");
    for (int k = 0; k < 3; k++) pop_chk(300 + k, "R8 newest");

    // R7: saturation
    fill(0);
    for (int k = 0; k < 65540; k++) push(k);
    get_event(16'hFFFF, "R7 saturated count");
    for (int i = 0; i < DEP; i++) pop_chk((65540 - DEP + i) & 16'hFFFF, "R7 last writes kept");
    check(q_empty, "R7 drained", int'(q_empty), 1);
    quiet(2 * QW, "R3 counter cleared after record");

    done = 1;
    summary();
  end
endmodule